// File: doc/BRIEF.md
# A/D Conversion Control Sequencer

This block is the digital side of an 8-bit analog-to-digital converter. Software programs one 8-bit control byte that picks the input channel, the conversion speed, whether an external trigger may start work, whether the converter is powered, and whether conversions run once or repeat. A run bit in the same byte starts and stops conversions. The block counts out each conversion in clock cycles. At the end of each conversion it takes the converter's sample into a result register and pulses a done strobe.

Any write to the control byte cancels the conversion in flight and sends the sequencer back to idle. A falling edge on the trigger pin can set the run bit in hardware. In single mode the hardware clears the run bit after one conversion. When the run bit falls and interrupts are enabled, the block pulses its interrupt output. The channel code goes out to the analog multiplexer, and the result comes in from a converter model.

Top module: `adc_seq_top`

## Requirements
- R1: The control byte resets to 00h. Its fields are: channel code in bits 7:5, slow select in bit 4, trigger enable in bit 3, power in bit 2, continuous in bit 1 and run in bit 0. A write with reg_addr=0 loads the byte. Reading with reg_addr=0 returns it on reg_rdata one cycle after the address is presented.
- R2: A control write cancels the conversion in progress. The cancelled conversion never produces conv_done. If the written byte has run=1 and power=1, a fresh conversion starts with its cycle count restarted.
- R3: A conversion lasts 78 cycles when bit 4 is 0 and 138 cycles when bit 4 is 1. Call the write's capturing clock edge W. After a write that sets run and power, conv_done is high for the one cycle after edge W+1+length.
- R4: With trigger enable set, a falling edge on ext_trig sets the run bit. ext_trig passes through a two-stage synchroniser first. If the pin falls just before edge A, the run bit is set at edge A+2. With trigger enable clear, trigger edges leave the run bit at 0.
- R5: With power at 0, no conversion starts and conv_done stays low. The run bit still holds its written value.
- R6: In single mode (bit 1 = 0), the run bit is cleared at the edge that ends the conversion. No further conversion follows until a new start.
- R7: In continuous mode (bit 1 = 1), conversions follow each other with no gap. conv_done pulses once every conversion length for as long as the run bit stays 1.
- R8: When the run bit changes from 1 to 0, for any reason, and irq_en is 1, irq is high for exactly one cycle. That cycle comes one cycle after the run bit's falling edge. With irq_en at 0, no pulse is produced.
- R9: The result register takes conv_sample on the final cycle of each conversion. conv_done is high for exactly one cycle. Reading with reg_addr=1 returns the result. Writes with reg_addr=1 leave both the result and the control byte unchanged.
- R10: chan_sel resets to 0. It takes the channel code from the control byte at the start of each conversion and holds that code until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 1 | Register select: 0 control, 1 result |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ext_trig | input | 1 | External trigger pin, active on falling edge |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | One-cycle interrupt pulse |
| chan_sel | output | 3 | Channel code latched for the current conversion |
| conv_sample | input | 8 | Sample value from the converter model |
| conv_done | output | 1 | One-cycle pulse when a result is loaded |

## Verification
The assertions assume that the control byte changes only through the write port, so power cannot drop during a conversion without a cancel. They also assume that ext_trig rests high between falling edges. The stimulus issues every control write as a single-cycle strobe and drives each trigger as one long low level followed by a return high. It holds conv_sample steady for the whole of a conversion, so the captured value is known without depending on sampling phase. It also keeps reads away from the cycle-counting windows, so that waiting on conv_done measures only the conversion length.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Control byte layout; bit positions are visible to software.
  typedef struct packed {
    logic [2:0] chan;
    logic       slow;
    logic       trg_en;
    logic       pwr;
    logic       cont;
    logic       run;
  } adc_ctrl_t;

  localparam int CTRL_W = $bits(adc_ctrl_t);

endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);

  logic [STAGES-1:0] sh;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b1;
        else     sh[i] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sh[i] <= 1'b1;
        else     sh[i] <= sh[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= sh[STAGES-1];
  end

  assign fall = prev & ~sh[STAGES-1];

  p_fall_single_r4: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);

endmodule

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              trig_fall,
  input  logic              hw_clr,
  output adc_ctrl_t         ctrl
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr) begin
      ctrl <= adc_ctrl_t'(wdata);
    end else if (trig_fall && ctrl.trg_en) begin
      ctrl.run <= 1'b1;
    end else if (hw_clr) begin
      ctrl.run <= 1'b0;
    end
  end

  p_wr_load_r1: assert property (@(posedge clk) disable iff (rst)
    wr |=> ctrl == $past(wdata));

  p_trig_run_r4: assert property (@(posedge clk) disable iff (rst)
    (trig_fall && ctrl.trg_en && !wr) |=> ctrl.run);

  p_no_trig_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr && !ctrl.trg_en && !ctrl.run) |=> !ctrl.run);

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int FAST_CYC = 78,
  parameter int SLOW_CYC = 138,
  parameter int CH_W     = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            abort,
  input  logic            pwr,
  input  logic            run,
  input  logic            slow,
  input  logic            cont,
  input  logic [CH_W-1:0] chan_in,
  output logic            busy,
  output logic            last,
  output logic            hw_clr,
  output logic [CH_W-1:0] chan_q
);

  localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] FAST_END = CNT_W'(FAST_CYC - 1);
  localparam logic [CNT_W-1:0] SLOW_END = CNT_W'(SLOW_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] end_val;

  assign end_val = slow ? SLOW_END : FAST_END;
  assign last    = busy && (cnt == end_val) && !abort;
  assign hw_clr  = last && !cont;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cnt    <= '0;
      chan_q <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (run && pwr) begin
        busy   <= 1'b1;
        cnt    <= '0;
        chan_q <= chan_in;
      end
    end else if (last) begin
      cnt <= '0;
      if (cont) chan_q <= chan_in;
      else      busy   <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= end_val);

  p_abort_idle_r2: assert property (@(posedge clk) disable iff (rst)
    abort |=> !busy);

  p_power_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> pwr);

  p_cont_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (last && cont) |=> (busy && cnt == '0));

  p_single_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (last && !cont) |=> !busy);

endmodule

// File: rtl/adc_result.sv
module adc_result #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] sample,
  input  logic              run,
  input  logic              irq_en,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic              irq
);

  logic run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
      run_q  <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (load) result <= sample;
      done  <= load;
      run_q <= run;
      irq   <= irq_en && run_q && !run;
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(result));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FAST_CYC    = 78,
  parameter int SLOW_CYC    = 138,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_addr,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_trig,
  input  logic              irq_en,
  output logic              irq,
  output logic [2:0]        chan_sel,
  input  logic [DATA_W-1:0] conv_sample,
  output logic              conv_done
);

  localparam int CH_W = 3;

  adc_ctrl_t         ctrl;
  logic              ctrl_wr;
  logic              trig_fall;
  logic              busy;
  logic              last;
  logic              hw_clr;
  logic [DATA_W-1:0] result;

  assign ctrl_wr = reg_wr && !reg_addr;

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_trig),
    .fall (trig_fall)
  );

  adc_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr        (ctrl_wr),
    .wdata     (reg_wdata),
    .trig_fall (trig_fall),
    .hw_clr    (hw_clr),
    .ctrl      (ctrl)
  );

  adc_conv_timer #(
    .FAST_CYC (FAST_CYC),
    .SLOW_CYC (SLOW_CYC),
    .CH_W     (CH_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .abort   (ctrl_wr),
    .pwr     (ctrl.pwr),
    .run     (ctrl.run),
    .slow    (ctrl.slow),
    .cont    (ctrl.cont),
    .chan_in (ctrl.chan),
    .busy    (busy),
    .last    (last),
    .hw_clr  (hw_clr),
    .chan_q  (chan_sel)
  );

  adc_result #(.DATA_W(DATA_W)) u_result (
    .clk    (clk),
    .rst    (rst),
    .load   (last),
    .sample (conv_sample),
    .run    (ctrl.run),
    .irq_en (irq_en),
    .result (result),
    .done   (conv_done),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (rst)           reg_rdata <= '0;
    else if (reg_addr) reg_rdata <= result;
    else               reg_rdata <= DATA_W'(ctrl);
  end

  p_abort_no_done_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> !conv_done);

  p_single_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (last && !ctrl.cont && !(trig_fall && ctrl.trg_en)) |=> !ctrl.run);

endmodule

// File: tb/adc_seq_top_bench.sv
module adc_seq_top_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_addr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_trig = 1'b1;
  logic       irq_en = 1'b0;
  logic       irq;
  logic [2:0] chan_sel;
  logic [4:0] tag = '0;
  logic [7:0] conv_sample;
  logic       conv_done;

  int checks = 0;
  int fails = 0;
  int irq_cnt = 0;
  int irq_wide = 0;
  int done_cnt = 0;
  logic irq_prev = 1'b0;

  always #5 clk = ~clk;

  assign conv_sample = {chan_sel, tag};

  adc_seq_top u_adc_seq_top (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_trig(ext_trig),
    .irq_en(irq_en), .irq(irq), .chan_sel(chan_sel),
    .conv_sample(conv_sample), .conv_done(conv_done)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (irq && irq_prev) irq_wide++;
    irq_prev = irq;
    if (conv_done) done_cnt++;
  end

  function automatic logic [7:0] mk(input int ch, input bit slow, input bit trg,
                                    input bit pwr, input bit cont, input bit run);
    return {3'(ch), slow, trg, pwr, cont, run};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    reg_addr = 1'b0;
  endtask

  task automatic wait_done(input int lim, output int n);
    n = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (conv_done) begin
        n = i;
        return;
      end
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, v0;
    int n, c0, d0, len;
    idle(3);
    rst = 1'b0;
    idle(1);

    // Reset state
    rd(1'b0, v);
    chk(v == 8'h00, "R1 reset ctrl", v, 0);
    chk(irq == 1'b0 && conv_done == 1'b0, "R1 reset outputs", {irq, conv_done}, 0);
    chk(chan_sel == 3'd0, "R10 reset chan_sel", chan_sel, 0);

    // Single-mode sweep over channels 0..4 and both speeds
    irq_en = 1'b1;
    for (int ch = 0; ch < 5; ch++) begin
      for (int s = 0; s < 2; s++) begin
        len = s ? 138 : 78;
        tag = 5'(ch * 2 + s + 1);
        c0 = irq_cnt;
        wr(1'b0, mk(ch, s[0], 0, 1, 0, 1));
        wait_done(300, n);
        chk(n == len + 1, "R3 conversion length", n, len + 1);
        chk(chan_sel == 3'(ch), "R10 channel latched", chan_sel, ch);
        @(negedge clk);
        chk(irq == 1'b1, "R8 irq one cycle after run falls", irq, 1);
        rd(1'b1, v);
        chk(v == {3'(ch), tag}, "R9 result value", v, {3'(ch), tag});
        rd(1'b0, v);
        chk(v[0] == 1'b0, "R6 run cleared in single mode", v[0], 0);
        d0 = done_cnt;
        idle(len + 10);
        chk(done_cnt == d0, "R6 no further conversion", done_cnt, d0);
        chk(irq_cnt == c0 + 1, "R8 one irq per conversion", irq_cnt, c0 + 1);
      end
    end
    chk(irq_wide == 0, "R8 irq width one cycle", irq_wide, 0);

    // Cancel mid-conversion by clearing run
    tag = 5'd17;
    wr(1'b0, mk(1, 1, 0, 1, 0, 1));
    idle(50);
    c0 = irq_cnt; d0 = done_cnt;
    wr(1'b0, mk(1, 1, 0, 1, 0, 0));
    idle(200);
    chk(done_cnt == d0, "R2 cancelled conversion gives no done", done_cnt, d0);
    chk(irq_cnt == c0 + 1, "R8 irq on software stop", irq_cnt, c0 + 1);

    // Restart: rewriting run restarts the count
    wr(1'b0, mk(1, 0, 0, 1, 0, 1));
    idle(40);
    wr(1'b0, mk(1, 0, 0, 1, 0, 1));
    wait_done(300, n);
    chk(n == 79, "R2 restart after rewrite", n, 79);
    idle(5);

    // Power off holds conversion
    d0 = done_cnt;
    wr(1'b0, mk(0, 0, 0, 0, 0, 1));
    idle(200);
    chk(done_cnt == d0, "R5 no conversion without power", done_cnt, d0);
    rd(1'b0, v);
    chk(v == mk(0, 0, 0, 0, 0, 1), "R5 run retained with power off", v, mk(0, 0, 0, 0, 0, 1));

    // Trigger enabled
    tag = 5'd9;
    wr(1'b0, mk(3, 0, 1, 1, 0, 0));
    idle(2);
    @(negedge clk);
    ext_trig = 1'b0;
    wait_done(300, n);
    chk(n == 82, "R4 trigger start latency", n, 82);
    chk(chan_sel == 3'd3, "R10 channel on triggered start", chan_sel, 3);
    idle(5);
    ext_trig = 1'b1;
    idle(5);

    // Trigger disabled
    d0 = done_cnt;
    wr(1'b0, mk(3, 0, 0, 1, 0, 0));
    idle(3);
    ext_trig = 1'b0;
    idle(10);
    rd(1'b0, v);
    chk(v[0] == 1'b0, "R4 disabled trigger leaves run clear", v[0], 0);
    idle(150);
    chk(done_cnt == d0, "R4 disabled trigger starts nothing", done_cnt, d0);
    ext_trig = 1'b1;
    idle(5);

    // Continuous mode
    tag = 5'd21;
    wr(1'b0, mk(2, 0, 0, 1, 1, 1));
    wait_done(300, n);
    chk(n == 79, "R7 first continuous conversion", n, 79);
    wait_done(300, n);
    chk(n == 78, "R7 back-to-back period", n, 78);
    wait_done(300, n);
    chk(n == 78, "R7 back-to-back period again", n, 78);
    c0 = irq_cnt;
    wr(1'b0, mk(2, 0, 0, 1, 1, 0));
    idle(5);
    chk(irq_cnt == c0 + 1, "R8 irq on continuous stop", irq_cnt, c0 + 1);
    rd(1'b1, v);
    chk(v == {3'd2, 5'd21}, "R9 continuous result", v, {3'd2, 5'd21});

    // Writes to the result address are ignored
    rd(1'b1, v0);
    rd(1'b0, v);
    wr(1'b1, ~v0);
    rd(1'b1, n == 0 ? v : v0);
    rd(1'b1, v0);
    chk(v0 == {3'd2, 5'd21}, "R9 result write ignored", v0, {3'd2, 5'd21});
    rd(1'b0, v0);
    chk(v0 == v, "R9 result write leaves ctrl", v0, v);

    // irq_en low suppresses pulse
    irq_en = 1'b0;
    c0 = irq_cnt;
    wr(1'b0, mk(4, 0, 0, 1, 0, 1));
    wait_done(300, n);
    chk(n == 79, "R3 fast length with irq disabled", n, 79);
    idle(10);
    chk(irq_cnt == c0, "R8 no irq when disabled", irq_cnt, c0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule